// File: doc/BRIEF.md
# ISA 16-bit Static RAM Card Decoder

This block is the control logic of a 16-bit-only ISA memory card that holds its storage in pairs of 512Kx8 static RAMs, one pair per 1 MB bank. It takes in the unlatched upper address lines LA[23:17], the latched system address, byte-high enable, the memory read and write strobes, ALE and a 4-bit configuration switch. From these it decides whether the current cycle belongs to one of its banks. It then drives the bus's 16-bit memory-select request, the per-byte SRAM chip enables, the shared SRAM output and write enables, and the data transceiver controls.

The host samples the 16-bit select only once, at the falling edge of ALE, so the select is decoded only from the upper lines. The upper lines are held in a latch that is transparent while ALE is high. Each bank covers a whole megabyte. Only LA[23:20] are compared with the bank's window, and LA[19:17] are ignored. The switch sets the base megabyte and can reduce the card to one bank. Base 0 lets the card replace all system memory from address 0. Because the card is built from static RAM, it has no refresh logic.

Top module: `isa_sram_decoder`

## Requirements
- R1: While `ale` is 1 the decode follows `la` at once. At each clock edge with `ale` high, `la` is captured. While `ale` is 0, changes on `la` have no effect on any output.
- R2: After reset, and until `ale` has been high at a clock edge, no bank hits. All enables stay deasserted and `memcs16_oe` is 0.
- R3: `memcs16_oe` is 1 exactly when the latched `la[6:3]` (LA[23:20]) equals the window of an enabled bank. `la[2:0]` (LA[19:17]) are don't-care. The result does not depend on the strobes.
- R4: Bank b answers at megabyte `cfg_sw[2:0] + b`. `cfg_sw=4'h1` places bank 0 at 0x100000–0x1FFFFF and bank 1 at 0x200000–0x2FFFFF. `cfg_sw=4'h0` places bank 0 at address 0.
- R5: When `cfg_sw[3]` is 1, only bank 0 can hit, and every higher bank stays deselected.
- R6: `ce_lo_n[b]` is 0 only when bank b hits, a strobe (`memr_n` or `memw_n`) is 0, and `sa[0]` is 0.
- R7: `ce_hi_n[b]` is 0 only when bank b hits, a strobe is 0, and `sbhe_n` is 0.
- R8: `oe_n` is 0 exactly when a bank hits and `memr_n` is 0. `we_n` is 0 exactly when a bank hits and `memw_n` is 0.
- R9: `buf_en_n` is 0 when a bank hits and a strobe is 0. A single enable serves both lanes. `buf_dir` is 1 (card to bus) only on a hit read, and 0 otherwise.
- R10: `ram_addr` equals `sa[19:1]`.
- R11: When no bank hits, all chip enables, `oe_n`, `we_n` and `buf_en_n` are 1, `buf_dir` is 0, and `memcs16_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the upper-address latch |
| rst_n | input | 1 | Active-low asynchronous reset |
| la | input | 7 | Unlatched upper address LA[23:17] |
| sa | input | 20 | Latched system address SA[19:0] |
| sbhe_n | input | 1 | Byte-high enable, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ale | input | 1 | Address latch enable |
| cfg_sw | input | 4 | [2:0] base megabyte, [3] single-bank mode |
| memcs16_oe | output | 1 | 1 = pull the open-collector 16-bit select line low |
| ram_addr | output | 19 | SRAM word address |
| ce_lo_n | output | 2 | Per-bank even-byte SRAM chip enable, active low |
| ce_hi_n | output | 2 | Per-bank odd-byte SRAM chip enable, active low |
| oe_n | output | 1 | SRAM output enable, active low |
| we_n | output | 1 | SRAM write enable, active low |
| buf_en_n | output | 1 | Data transceiver enable, active low |
| buf_dir | output | 1 | Transceiver direction, 1 = card to bus |

## Verification
The bench builds the block with its default of two banks, a 7-bit upper field and a 20-bit system address. With two banks, bank 1 is available to show adjacent-window hits, bank-1 lane selection and the single-bank switch setting. The vectors use base settings 0, 1 and 5, which cover the default test map, the map from address 0 and a high window. In each vector `la` is inverted after ALE falls, so that any leak through the latch changes the decode.

// File: rtl/isa_sram_pkg.sv
package isa_sram_pkg;

  localparam int LA_W   = 7;   // LA[23:17]
  localparam int MB_W   = 4;   // LA[23:20] select the megabyte
  localparam int CFG_W  = 4;
  localparam int BASE_W = 3;   // cfg bits holding the base megabyte
  localparam int SINGLE_BIT = 3;

  typedef logic [MB_W-1:0] mb_idx_t;

  // Megabyte field of the upper address (bits below it are don't-care).
  function automatic mb_idx_t mb_of(logic [LA_W-1:0] la_v);
    return la_v[LA_W-1 -: MB_W];
  endfunction

  // Megabyte window assigned to a bank under a switch setting.
  function automatic mb_idx_t window_of(logic [CFG_W-1:0] cfg, int unsigned bank);
    return MB_W'(cfg[BASE_W-1:0]) + MB_W'(bank);
  endfunction

  // Whether a bank is allowed to answer under a switch setting.
  function automatic logic bank_allowed(logic [CFG_W-1:0] cfg, int unsigned bank);
    return !(cfg[SINGLE_BIT] && (bank != 0));
  endfunction

endpackage

// File: rtl/isa_la_latch.sv
module isa_la_latch
  import isa_sram_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LA_W-1:0] la,
  output logic [LA_W-1:0] la_eff,
  output logic            la_valid
);

  logic [LA_W-1:0] la_hold;
  logic            seen_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_hold  <= '0;
      seen_ale <= 1'b0;
    end else if (ale) begin
      la_hold  <= la;
      seen_ale <= 1'b1;
    end
  end

  // Transparent while ALE is high, holding afterwards.
  assign la_eff   = ale ? la : la_hold;
  assign la_valid = ale | seen_ale;

endmodule

// File: rtl/isa_bank_match.sv
module isa_bank_match
  import isa_sram_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic [LA_W-1:0]      la_eff,
  input  logic                 la_valid,
  input  logic [CFG_W-1:0]     cfg_sw,
  output logic [NUM_BANKS-1:0] bank_hit
);

  mb_idx_t mb_now;
  assign mb_now = mb_of(la_eff);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = la_valid
                       && bank_allowed(cfg_sw, b)
                       && (mb_now == window_of(cfg_sw, b));
  end

endmodule

// File: rtl/isa_sram_ctl.sv
module isa_sram_ctl #(
  parameter int NUM_BANKS = 2
) (
  input  logic [NUM_BANKS-1:0] bank_hit,
  input  logic                 sa0,
  input  logic                 sbhe_n,
  input  logic                 memr_n,
  input  logic                 memw_n,
  output logic [NUM_BANKS-1:0] ce_lo_n,
  output logic [NUM_BANKS-1:0] ce_hi_n,
  output logic                 oe_n,
  output logic                 we_n,
  output logic                 buf_en_n,
  output logic                 buf_dir,
  output logic                 any_hit,
  output logic                 strobe_act
);

  logic rd_act, wr_act;

  assign any_hit    = |bank_hit;
  assign rd_act     = !memr_n;
  assign wr_act     = !memw_n;
  assign strobe_act = rd_act | wr_act;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    assign ce_lo_n[b] = !(bank_hit[b] && strobe_act && !sa0);
    assign ce_hi_n[b] = !(bank_hit[b] && strobe_act && !sbhe_n);
  end

  assign oe_n     = !(any_hit && rd_act);
  assign we_n     = !(any_hit && wr_act);
  assign buf_en_n = !(any_hit && strobe_act);
  assign buf_dir  = any_hit && rd_act;

endmodule

// File: rtl/isa_sram_decoder.sv
module isa_sram_decoder
  import isa_sram_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SA_W      = 20,
  localparam int RA_W     = SA_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LA_W-1:0]      la,
  input  logic [SA_W-1:0]      sa,
  input  logic                 sbhe_n,
  input  logic                 memr_n,
  input  logic                 memw_n,
  input  logic                 ale,
  input  logic [CFG_W-1:0]     cfg_sw,
  output logic                 memcs16_oe,
  output logic [RA_W-1:0]      ram_addr,
  output logic [NUM_BANKS-1:0] ce_lo_n,
  output logic [NUM_BANKS-1:0] ce_hi_n,
  output logic                 oe_n,
  output logic                 we_n,
  output logic                 buf_en_n,
  output logic                 buf_dir
);

  logic [LA_W-1:0]      la_eff;
  logic                 la_valid;
  logic [NUM_BANKS-1:0] bank_hit;
  logic                 any_hit;
  logic                 strobe_act;

  isa_la_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .la       (la),
    .la_eff   (la_eff),
    .la_valid (la_valid)
  );

  isa_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .la_eff   (la_eff),
    .la_valid (la_valid),
    .cfg_sw   (cfg_sw),
    .bank_hit (bank_hit)
  );

  isa_sram_ctl #(.NUM_BANKS(NUM_BANKS)) u_ctl (
    .bank_hit   (bank_hit),
    .sa0        (sa[0]),
    .sbhe_n     (sbhe_n),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .ce_lo_n    (ce_lo_n),
    .ce_hi_n    (ce_hi_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .buf_en_n   (buf_en_n),
    .buf_dir    (buf_dir),
    .any_hit    (any_hit),
    .strobe_act (strobe_act)
  );

  // The select comes from the upper-address decode only, never from the strobes.
  assign memcs16_oe = any_hit;
  assign ram_addr   = sa[SA_W-1:1];

endmodule

// File: rtl/isa_sram_decoder_chk.sv
module isa_sram_decoder_chk
  import isa_sram_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SA_W      = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SA_W-1:0]      sa,
  input logic                 sbhe_n,
  input logic                 memr_n,
  input logic                 memw_n,
  input logic                 ale,
  input logic [CFG_W-1:0]     cfg_sw,
  input logic                 memcs16_oe,
  input logic [NUM_BANKS-1:0] ce_lo_n,
  input logic [NUM_BANKS-1:0] ce_hi_n,
  input logic                 oe_n,
  input logic                 we_n,
  input logic                 buf_en_n,
  input logic                 buf_dir,
  input logic [NUM_BANKS-1:0] bank_hit
);

  // R1
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale) && $stable(cfg_sw)) |-> $stable(memcs16_oe));

  // R5
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sw[SINGLE_BIT] |-> ((bank_hit >> 1) == '0));

  // R6
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~ce_lo_n != '0) |-> (!sa[0] && (!memr_n || !memw_n)));

  // R7
  hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~ce_hi_n != '0) |-> (!sbhe_n && (!memr_n || !memw_n)));

  // R8
  oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!memr_n && memcs16_oe));

  // R8
  we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!memw_n && memcs16_oe));

  // R9
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_dir |-> (!memr_n && !buf_en_n));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memcs16_oe |-> (&ce_lo_n && &ce_hi_n && oe_n && we_n && buf_en_n && !buf_dir));

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

endmodule

bind isa_sram_decoder isa_sram_decoder_chk #(.NUM_BANKS(NUM_BANKS), .SA_W(SA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sa         (sa),
  .sbhe_n     (sbhe_n),
  .memr_n     (memr_n),
  .memw_n     (memw_n),
  .ale        (ale),
  .cfg_sw     (cfg_sw),
  .memcs16_oe (memcs16_oe),
  .ce_lo_n    (ce_lo_n),
  .ce_hi_n    (ce_hi_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .buf_en_n   (buf_en_n),
  .buf_dir    (buf_dir),
  .bank_hit   (bank_hit)
);

// File: tb/tb_isa_sram_decoder.sv
`timescale 1ns/1ps
module tb_isa_sram_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  la = '0;
  logic [19:0] sa = '0;
  logic        sbhe_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1, ale = 1'b0;
  logic [3:0]  cfg_sw = '0;
  logic        memcs16_oe, oe_n, we_n, buf_en_n, buf_dir;
  logic [18:0] ram_addr;
  logic [1:0]  ce_lo_n, ce_hi_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  isa_sram_decoder dut (
    .clk(clk), .rst_n(rst_n), .la(la), .sa(sa), .sbhe_n(sbhe_n),
    .memr_n(memr_n), .memw_n(memw_n), .ale(ale), .cfg_sw(cfg_sw),
    .memcs16_oe(memcs16_oe), .ram_addr(ram_addr), .ce_lo_n(ce_lo_n),
    .ce_hi_n(ce_hi_n), .oe_n(oe_n), .we_n(we_n), .buf_en_n(buf_en_n),
    .buf_dir(buf_dir)
  );

  typedef struct packed {
    logic [3:0] cfg;
    logic [6:0] la;
    logic       sa0, sbhe_n, memr_n, memw_n;
    logic       cs16;
    logic [1:0] ce_lo_n, ce_hi_n;
    logic       oe_n, we_n, buf_en_n, buf_dir;
  } vec_t;

  localparam int NV = 11;
  // cfg, la, sa0, sbhe_n, memr_n, memw_n | cs16, ce_lo_n, ce_hi_n, oe_n, we_n, buf_en_n, buf_dir
  localparam vec_t VEC [NV] = '{
    '{4'h1, 7'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 R6 R7 bank0 word read
    '{4'h1, 7'h0F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 don't-care bits, hi write
    '{4'h1, 7'h10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 bank1 lo read
    '{4'h1, 7'h18, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0}, // R11 miss above
    '{4'h1, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0}, // R11 miss below
    '{4'h0, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 base at 0
    '{4'h0, 7'h0B, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 bank1 word write
    '{4'h8, 7'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 bank1 disabled
    '{4'h8, 7'h05, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 bank0 still live
    '{4'h1, 7'h08, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 R9 select without strobe
    '{4'h5, 7'h30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1}  // R4 base 5 bank1 hi read
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    memr_n = 1'b1; memw_n = 1'b1; sbhe_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset state (R2, R11)
    cfg_sw = 4'h0; memr_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 cs16 before first ALE", memcs16_oe, 1'b0);
    chk("R2 oe_n before first ALE", oe_n, 1'b1);
    chk("R11 ce_lo_n idle", ce_lo_n, 2'b11);
    idle_strobes();

    // Vector table: ALE high with la, then ALE low and la inverted (R1 hold)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_sw = VEC[i].cfg; la = VEC[i].la; ale = 1'b1;
      @(negedge clk);
      ale = 1'b0; la = ~VEC[i].la;
      sa = {19'h1234 + 19'(i), VEC[i].sa0};
      sbhe_n = VEC[i].sbhe_n; memr_n = VEC[i].memr_n; memw_n = VEC[i].memw_n;
      @(negedge clk); #1;
      chk($sformatf("R1 R3 cs16 vec%0d", i), memcs16_oe, VEC[i].cs16);
      chk($sformatf("R6 ce_lo_n vec%0d", i), ce_lo_n, VEC[i].ce_lo_n);
      chk($sformatf("R7 ce_hi_n vec%0d", i), ce_hi_n, VEC[i].ce_hi_n);
      chk($sformatf("R8 oe_n vec%0d", i), oe_n, VEC[i].oe_n);
      chk($sformatf("R8 we_n vec%0d", i), we_n, VEC[i].we_n);
      chk($sformatf("R9 buf_en_n vec%0d", i), buf_en_n, VEC[i].buf_en_n);
      chk($sformatf("R9 buf_dir vec%0d", i), buf_dir, VEC[i].buf_dir);
      idle_strobes();
    end

    // R1: transparent while ALE high, before any clock edge
    @(negedge clk);
    cfg_sw = 4'h1; la = 7'h18; ale = 1'b1; #1;
    chk("R1 transparent miss", memcs16_oe, 1'b0);
    la = 7'h09; #1;
    chk("R1 transparent hit", memcs16_oe, 1'b1);
    @(negedge clk);
    ale = 1'b0; la = 7'h7F; #1;
    chk("R1 held after fall", memcs16_oe, 1'b1);
    repeat (2) @(negedge clk); #1;
    chk("R1 held later", memcs16_oe, 1'b1);

    // R10: SRAM word address
    sa = 20'hABCDE; #1;
    chk("R10 ram_addr", ram_addr, 19'h55E6F);

    // R2: a new reset clears the captured window
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; memr_n = 1'b0;
    @(negedge clk); #1;
    chk("R2 cs16 after re-reset", memcs16_oe, 1'b0);
    chk("R11 buf_en_n after re-reset", buf_en_n, 1'b1);
    idle_strobes();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule